// File: doc/BRIEF.md
# Multiplier-free 16-tap FIR filter (bit-parallel distributed arithmetic)

This block filters a stream of signed 16-bit samples with a fixed set of 16 coefficients. It uses no multipliers. At elaboration, each group of four neighbouring taps gets a 16-entry table of partial sums. Every entry is the sum of the group's coefficients whose address bit is set.

When a sample is accepted, the delay line shifts. Then, for every bit position at once, the bits of that position across a group's four taps form the table address. The table results of the four groups are added to give one partial sum per bit position. These sums are weighted by powers of two, with the sign-bit position subtracted, and then reduced in a pipelined adder tree. The result is one filtered sample per accepted input.

Each table instance has two read ports and serves two bit positions. The 16 taps are therefore covered by 32 small tables. The full-precision result is 36 bits wide. It is reduced to the output width by an arithmetic right shift that is fixed by a parameter.

Top module: `dafir_fir`

## Requirements
- R1: While `rst` is high at a rising edge, `out_valid` and `out_data` are cleared to zero and the delay line is emptied. The first sample after reset therefore sees all older taps as zero.
- R2: For each accepted sample, `out_data` equals bits [35:20] of the exact sum Σ c[k]·x[n-k], k = 0..15. Samples and coefficients are 16-bit two's complement, x[n] is the sample just accepted (tap 0), and the default coefficients are c[0..15] = 120, -340, 910, -2048, 4095, 8000, -12000, 32767, -32768, 15000, -7000, 3000, -1500, 700, -250, 64.
- R3: `out_valid` is high in exactly one cycle per accepted sample, four rising edges after the edge that samples `in_valid` high. Results leave in the order the samples arrived.
- R4: A rising edge with `in_valid` low leaves the delay line unchanged, whatever `in_data` carries. Later results show no trace of that data.
- R5: The sign bit of every sample carries weight -2^15, so the most negative input 0x8000 and full-scale alternation are filtered exactly.
- R6: While `out_valid` is low, `out_data` keeps the last result (zero after reset).
- R7: Samples accepted on consecutive cycles produce results on consecutive cycles, one per cycle, with no loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_data | input | 16 | Input sample, two's complement |
| out_valid | output | 1 | Result strobe |
| out_data | output | 16 | Filtered sample, bits [35:20] of the full sum |

## Verification
The bench drives full-scale negative runs and alternation between the two extremes. A design that added the sign-bit partial sum instead of subtracting it would be off by a large margin on exactly these inputs.

Idle cycles carry junk on the data input. A delay line that shifts without the strobe would corrupt every later result. A mid-stream reset is followed by a single sample, which exposes any history that survives reset.

Back-to-back bursts and random gaps check both the four-edge latency and that every sample gives exactly one result. A pipeline with a wrong depth, or a valid chain out of step with the data, would report the wrong value or the wrong cycle.

// File: rtl/dafir_pkg.sv
package dafir_pkg;
    // taps addressed together by one partial-sum table
    localparam int DAFIR_GRP  = 4;
    // bit positions combined in the first weighting stage
    localparam int DAFIR_QUAD = 4;
    // edges from sampling in_valid to out_valid
    localparam int DAFIR_LAT  = 4;
endpackage

// File: rtl/dafir_rom.sv
module dafir_rom #(
    parameter int COEF_W = 16,
    parameter int GRP    = 4,
    parameter logic [GRP*COEF_W-1:0] GCOEF = '0
) (
    input  logic [GRP-1:0]                        addr_a,
    input  logic [GRP-1:0]                        addr_b,
    output logic signed [COEF_W+$clog2(GRP)-1:0]  val_a,
    output logic signed [COEF_W+$clog2(GRP)-1:0]  val_b
);
    localparam int EW  = COEF_W + $clog2(GRP);
    localparam int ENT = 1 << GRP;

    function automatic longint entry_of(input int a);
        longint s;
        s = 0;
        for (int j = 0; j < GRP; j++) begin
            if (((a >> j) & 1) != 0)
                s += longint'($signed(GCOEF[j*COEF_W +: COEF_W]));
        end
        return s;
    endfunction

    logic signed [EW-1:0] tbl [ENT];

    for (genvar e = 0; e < ENT; e++) begin : g_ent
        assign tbl[e] = EW'(entry_of(e));
    end

    assign val_a = tbl[addr_a];
    assign val_b = tbl[addr_b];
endmodule

// File: rtl/dafir_wsum.sv
module dafir_wsum #(
    parameter int N       = 4,
    parameter int IW      = 20,
    parameter int OW      = 24,
    parameter int STEP    = 1,
    parameter bit NEG_MSB = 1'b0
) (
    input  logic [N-1:0][IW-1:0] terms,
    output logic signed [OW-1:0] total
);
    always_comb begin
        total = '0;
        for (int i = 0; i < N; i++) begin
            logic signed [OW-1:0] t;
            t = OW'($signed(terms[i]));
            t = t <<< (i * STEP);
            if (NEG_MSB && (i == N - 1))
                total = total - t;
            else
                total = total + t;
        end
    end
endmodule

// File: rtl/dafir_fir.sv
module dafir_fir
    import dafir_pkg::*;
#(
    parameter int TAPS      = 16,
    parameter int IN_W      = 16,
    parameter int COEF_W    = 16,
    parameter int OUT_W     = 16,
    parameter int OUT_SHIFT = 20,
    parameter logic [TAPS*COEF_W-1:0] COEFS = {
        16'h0040, 16'hFF06, 16'h02BC, 16'hFA24,
        16'h0BB8, 16'hE4A8, 16'h3A98, 16'h8000,
        16'h7FFF, 16'hD120, 16'h1F40, 16'h0FFF,
        16'hF800, 16'h038E, 16'hFEAC, 16'h0078
    }
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_data,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_data
);
    localparam int GRP   = DAFIR_GRP;
    localparam int NGRP  = TAPS / GRP;
    localparam int EW    = COEF_W + $clog2(GRP);
    localparam int BS_W  = COEF_W + $clog2(TAPS);
    localparam int NQ    = IN_W / DAFIR_QUAD;
    localparam int QW    = BS_W + DAFIR_QUAD;
    localparam int ACC_W = IN_W + COEF_W + $clog2(TAPS);
    localparam int LAT   = DAFIR_LAT;
    localparam int NPAIR = IN_W / 2;

    typedef struct packed {
        logic [LAT:0]                 vld;
        logic [TAPS-1:0][IN_W-1:0]    taps;
        logic [IN_W-1:0][BS_W-1:0]    bsum;
        logic [NQ-1:0][QW-1:0]        quad;
        logic [ACC_W-1:0]             acc;
        logic [OUT_W-1:0]             out;
    } st_t;

    st_t st_q, st_d;

    // table addresses: per group, per bit position, one bit from each tap
    logic [NGRP-1:0][IN_W-1:0][GRP-1:0] addr;
    logic signed [EW-1:0] rom_o [NGRP][IN_W];

    always_comb begin
        for (int g = 0; g < NGRP; g++)
            for (int b = 0; b < IN_W; b++)
                for (int j = 0; j < GRP; j++)
                    addr[g][b][j] = st_q.taps[g*GRP + j][b];
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        for (genvar p = 0; p < NPAIR; p++) begin : g_pair
            dafir_rom #(
                .COEF_W (COEF_W),
                .GRP    (GRP),
                .GCOEF  (COEFS[g*GRP*COEF_W +: GRP*COEF_W])
            ) u_rom (
                .addr_a (addr[g][2*p]),
                .addr_b (addr[g][2*p+1]),
                .val_a  (rom_o[g][2*p]),
                .val_b  (rom_o[g][2*p+1])
            );
        end
    end

    // weight bit sums inside each quad; the top quad holds the sign bit
    logic signed [QW-1:0] quad_w [NQ];

    for (genvar q = 0; q < NQ; q++) begin : g_quad
        dafir_wsum #(
            .N       (DAFIR_QUAD),
            .IW      (BS_W),
            .OW      (QW),
            .STEP    (1),
            .NEG_MSB (q == NQ - 1)
        ) u_qsum (
            .terms (st_q.bsum[q*DAFIR_QUAD +: DAFIR_QUAD]),
            .total (quad_w[q])
        );
    end

    logic signed [ACC_W-1:0] acc_w;

    dafir_wsum #(
        .N       (NQ),
        .IW      (QW),
        .OW      (ACC_W),
        .STEP    (DAFIR_QUAD),
        .NEG_MSB (1'b0)
    ) u_fsum (
        .terms (st_q.quad),
        .total (acc_w)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = {st_q.vld[LAT-1:0], in_valid};
        if (in_valid)
            st_d.taps = {st_q.taps[TAPS-2:0], in_data};
        for (int b = 0; b < IN_W; b++) begin
            logic signed [BS_W-1:0] s;
            s = '0;
            for (int g = 0; g < NGRP; g++)
                s = s + BS_W'(rom_o[g][b]);
            st_d.bsum[b] = s;
        end
        for (int q = 0; q < NQ; q++)
            st_d.quad[q] = quad_w[q];
        st_d.acc = acc_w;
        if (st_q.vld[LAT-1])
            st_d.out = st_q.acc[OUT_SHIFT +: OUT_W];
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign out_valid = st_q.vld[LAT];
    assign out_data  = st_q.out;
endmodule

// File: rtl/dafir_fir_chk.sv
module dafir_fir_chk #(
    parameter int OUT_W    = 16,
    parameter int TAP_BITS = 256
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic                out_valid,
    input logic [OUT_W-1:0]    out_data,
    input logic [TAP_BITS-1:0] taps
);
    logic [2:0] age;

    always_ff @(posedge clk) begin
        if (rst)
            age <= '0;
        else if (age != 3'd7)
            age <= age + 3'd1;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0));

    // R3
    no_orphan_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 5));

    // R3
    no_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (age >= 3'd5 && $past(in_valid, 5)) |-> out_valid);

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(taps));

    // R6
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_data));
endmodule

bind dafir_fir dafir_fir_chk #(
    .OUT_W    (OUT_W),
    .TAP_BITS (TAPS*IN_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_data  (out_data),
    .taps      (st_q.taps)
);

// File: tb/dafir_fir_bench.sv
module dafir_fir_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [15:0] in_data;
    logic        out_valid;
    logic [15:0] out_data;

    always #2 clk = ~clk;

    dafir_fir u_dafir_fir (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    typedef struct {
        logic [15:0] d;
        int          t;
        string       tag;
    } item_t;

    item_t  sb[$];
    int     total = 0;
    int     bad   = 0;
    int     cyc   = 0;
    bit     done  = 0;
    longint hist[16];
    logic [15:0] last_out = '0;
    logic [15:0] lfsr = 16'hACE1;

    const int coef[16] = '{120, -340, 910, -2048, 4095, 8000, -12000, 32767,
                           -32768, 15000, -7000, 3000, -1500, 700, -250, 64};

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic clear_model();
        for (int k = 0; k < 16; k++) hist[k] = 0;
    endtask

    // driver: presents one sample and queues its expected result
    task automatic send(input logic [15:0] x, input string tag);
        longint acc;
        item_t it;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = x;
        for (int k = 15; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = longint'($signed(x));
        acc = 0;
        for (int k = 0; k < 16; k++) acc += longint'(coef[k]) * hist[k];
        it.d   = 16'(acc >>> 20);
        it.t   = cyc;
        it.tag = tag;
        sb.push_back(it);
    endtask

    // idle cycles carry junk on the data input (R4)
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            lfsr     = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            in_data  = lfsr;
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst) begin
            last_out = '0;
        end else if (out_valid) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R3 unexpected result", longint'(out_data), 0);
            end else begin
                item_t it;
                it = sb.pop_front();
                chk(out_data == it.d, it.tag, longint'($signed(out_data)), longint'($signed(it.d)));
                chk(cyc - it.t == 5, "R3 latency", cyc - it.t, 5);
            end
            last_out = out_data;
        end else begin
            chk(out_data == last_out, "R6 hold", longint'(out_data), longint'(last_out));
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", cyc, 100000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst      = 1'b1;
        in_valid = 1'b0;
        in_data  = '0;
        clear_model();
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 reset valid", out_valid, 0);
        chk(out_data == '0, "R1 reset data", out_data, 0);
        rst = 1'b0;

        // single sample on an empty delay line (R1, R2)
        send(16'h4000, "R1 empty history");
        idle(8);

        // back-to-back full-scale positive run (R7)
        for (int i = 0; i < 20; i++) send(16'h7FFF, "R7 burst");
        // most negative value (R5)
        for (int i = 0; i < 20; i++) send(16'h8000, "R5 min value");
        // alternate between the extremes (R5)
        for (int i = 0; i < 16; i++) send((i % 2 == 0) ? 16'h7FFF : 16'h8000, "R5 alternate");
        idle(3);

        // pseudo-random data with random gaps (R2, R4)
        for (int i = 0; i < 80; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[0]) idle(1 + int'(lfsr[3:2]));
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            send(lfsr, "R2 random");
        end
        idle(10);
        chk(sb.size() == 0, "R3 drained", sb.size(), 0);

        // reset in mid stream: history must be gone (R1)
        for (int i = 0; i < 6; i++) send(16'h1234 + 16'(i * 977), "R2 ramp");
        idle(8);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 mid reset valid", out_valid, 0);
        chk(out_data == '0, "R1 mid reset data", out_data, 0);
        rst = 1'b0;
        clear_model();
        send(16'hC000, "R1 after reset");
        send(16'h0000, "R1 after reset");
        idle(8);

        // slow ramp, one sample every other cycle (R2, R4)
        for (int i = 0; i < 24; i++) begin
            send(16'(i * 2731 - 30000), "R2 ramp");
            idle(1);
        end
        idle(10);
        chk(sb.size() == 0, "R3 all results seen", sb.size(), 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule